// File: doc/BRIEF.md
# Descriptor Ring Fetch Engine

This block walks a ring of transfer descriptors that software builds in memory, one endpoint at a time. Each descriptor is twelve bytes long: a buffer pointer word at the descriptor address, a length word four bytes above it, and a control word eight bytes above it. All three are 32-bit little-endian words and are read one at a time through a simple memory-read port. Software marks a descriptor as ready by writing its cycle bit to match the engine's consumer cycle state. The engine checks that bit, sends normal descriptors to a data mover, and jumps across link descriptors. A link descriptor with its toggle flag set also inverts the cycle state, so that ring entries left over from the previous lap read as not ready.

A doorbell starts the engine from idle. From then on it consumes descriptors one after another and does not wait for further doorbells. It stops when it meets a descriptor that it does not own, raises a descriptor-missing status, and waits for the next doorbell at that same descriptor. Completions, short packets, overruns and malformed descriptors set sticky status bits, which are cleared by writing ones. The interrupt line combines these bits with per-bit enables. An endpoint reset clears the engine and sets its fetch position to the ring base.

Top module: `trb_ring_fetcher`

## Requirements
- R1: A descriptor at address A is read as three words at A, A+4 and A+8, each through a single-cycle `mem_rd_en` pulse. The next word is requested only after `mem_rd_valid` returns the previous one.
- R2: A descriptor is owned only when control bit 0 equals the consumer cycle state. The cycle state is 1 after either reset. A descriptor that is not owned sets status bit 4 and returns the engine to idle, and the fetch position stays on that descriptor.
- R3: A descriptor whose type field (control bits 15:10) is 1 drives `xfer_valid` with `xfer_addr` = buffer word, `xfer_len` = length bits 16:0 and `xfer_burst` = length bits 31:24. These values are held stable until `xfer_ready`.
- R4: A descriptor of type 6 moves the fetch position to its buffer word with bits 1:0 cleared and starts no transfer. When control bit 1 is set, the cycle state inverts.
- R5: After a completion the fetch position advances by 12 bytes and the next descriptor is fetched without a doorbell. Control bit 5 on a completed descriptor sets status bit 2.
- R6: If `done_len` is smaller than the descriptor length, the transfer is short. Status bit 3 is set if control bit 2 is set. If control bit 4 (chain) was set, every following chained descriptor is consumed without a transfer, and status bit 2 then follows only the control bit 5 of the last descriptor of the chain (chain bit clear).
- R7: If `done_len` is larger than the descriptor length, status bit 14 is set.
- R8: A normal-mode descriptor whose type is neither 1 nor 6 sets status bit 7 and halts the engine. While halted, `busy` is low and doorbells start no reads, until an endpoint reset.
- R9: Status bits 2, 3, 4, 7 and 14 are sticky and are cleared by writing ones through `sts_clr_mask` with `sts_clr_valid`; a bit that is not written keeps its value. Bit 9 shows `busy` and bit 11 shows the cycle state.
- R10: `irq` is high when bit 2 or bit 3 is set, or when bit 4, 7 or 14 is set together with the enable bit at the same position in `sts_irq_en`.
- R11: `ep_reset` sets the engine idle, the fetch position to `ring_base`, the cycle state to 1, and clears the skip state and all sticky bits, so that `sts_q` reads 0x0800. Power-up reset gives the same status but sets the fetch position to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | ADDR_W | Ring start address, loaded on endpoint reset |
| doorbell | input | 1 | Restart fetching when idle |
| ep_reset | input | 1 | Endpoint reset command |
| mem_rd_en | output | 1 | Word read request pulse |
| mem_rd_addr | output | ADDR_W | Byte address of requested word |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | DATA_W | Read data word |
| xfer_valid | output | 1 | Transfer request to data mover |
| xfer_ready | input | 1 | Data mover accepts the request |
| xfer_addr | output | ADDR_W | Buffer address of the transfer |
| xfer_len | output | LEN_W | Requested transfer length in bytes |
| xfer_burst | output | BURST_W | Burst size field |
| done_valid | input | 1 | Transfer finished |
| done_len | input | LEN_W | Bytes actually moved |
| sts_clr_valid | input | 1 | Status write strobe |
| sts_clr_mask | input | STS_W | Ones clear the matching sticky bits |
| sts_irq_en | input | STS_W | Interrupt enables for bits 4, 7, 14 |
| sts_q | output | STS_W | Status word |
| irq | output | 1 | Interrupt request |
| ccs | output | 1 | Consumer cycle state |
| busy | output | 1 | Engine is fetching or transferring |

## Verification
The hardest case to reach is a short packet in the middle of a chain, because the engine then has to go through the rest of the chain without starting any transfer and take the completion flag from the last descriptor only. The bench builds a three-descriptor chain in its memory model, finishes only the first transfer with a short length, and watches `xfer_valid` on every clock while the engine consumes the remaining descriptors. Cycle-state inversion is reached in a similar way: a toggling link points back at a descriptor that is still marked with the previous lap's cycle bit, which must then be reported as missing.

// File: rtl/trb_fetch_pkg.sv
package trb_fetch_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_ISSUE, S_WAIT, S_HALT
  } fetch_state_t;

  localparam int unsigned DESC_BYTES = 12;
  localparam logic [5:0] KIND_NORMAL = 6'd1;
  localparam logic [5:0] KIND_LINK   = 6'd6;

  // control word bit positions
  localparam int unsigned C_CYCLE  = 0;
  localparam int unsigned C_TOGGLE = 1;
  localparam int unsigned C_SPKT   = 2;
  localparam int unsigned C_CHAIN  = 4;
  localparam int unsigned C_DONEIRQ = 5;

  // status word bit positions
  localparam int unsigned ST_DONE  = 2;
  localparam int unsigned ST_SHORT = 3;
  localparam int unsigned ST_MISS  = 4;
  localparam int unsigned ST_BAD   = 7;
  localparam int unsigned ST_BUSY  = 9;
  localparam int unsigned ST_CYC   = 11;
  localparam int unsigned ST_OVER  = 14;

  function automatic logic [5:0] desc_kind(input logic [31:0] ctl);
    return ctl[15:10];
  endfunction

  function automatic logic [16:0] desc_len(input logic [31:0] lw);
    return lw[16:0];
  endfunction

  function automatic logic [7:0] desc_burst(input logic [31:0] lw);
    return lw[31:24];
  endfunction

  function automatic logic [31:0] link_target(input logic [31:0] bw);
    return bw & 32'hFFFF_FFFC;
  endfunction

endpackage

// File: rtl/trb_word_loader.sv
module trb_word_loader #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         kill,
  input  logic                         start,
  input  logic [ADDR_W-1:0]            base,
  output logic                         mem_rd_en,
  output logic [ADDR_W-1:0]            mem_rd_addr,
  input  logic                         mem_rd_valid,
  input  logic [DATA_W-1:0]            mem_rd_data,
  output logic [WORDS-1:0][DATA_W-1:0] words,
  output logic                         done
);
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  logic             active;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      idx         <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      words       <= '0;
      done        <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      done      <= 1'b0;
      if (kill) begin
        active <= 1'b0;
      end else if (start) begin
        active      <= 1'b1;
        idx         <= '0;
        mem_rd_en   <= 1'b1;
        mem_rd_addr <= base;
      end else if (active && mem_rd_valid) begin
        words[idx] <= mem_rd_data;
        if (idx == LAST) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          idx         <= idx + 1'b1;
          mem_rd_en   <= 1'b1;
          mem_rd_addr <= mem_rd_addr + STEP;
        end
      end
    end
  end
endmodule

// File: rtl/trb_status_bank.sv
module trb_status_bank
  import trb_fetch_pkg::*;
#(
  parameter int unsigned STS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic [STS_W-1:0] set_mask,
  input  logic [STS_W-1:0] clr_mask,
  input  logic [STS_W-1:0] irq_en,
  input  logic             busy,
  input  logic             cyc,
  output logic [STS_W-1:0] sts,
  output logic             irq
);
  localparam logic [STS_W-1:0] ONE      = STS_W'(1);
  localparam logic [STS_W-1:0] ALWAYS   = (ONE << ST_DONE) | (ONE << ST_SHORT);
  localparam logic [STS_W-1:0] GATED    = (ONE << ST_MISS) | (ONE << ST_BAD) | (ONE << ST_OVER);
  localparam logic [STS_W-1:0] STICKY   = ALWAYS | GATED;

  logic [STS_W-1:0] sticky_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sticky_q <= '0;
    else if (kill) sticky_q <= '0;
    else           sticky_q <= ((sticky_q & ~clr_mask) | set_mask) & STICKY;
  end

  always_comb begin
    sts = sticky_q;
    sts[ST_BUSY] = busy;
    sts[ST_CYC]  = cyc;
    irq = |(sticky_q & (ALWAYS | (irq_en & GATED)));
  end
endmodule

// File: rtl/trb_ring_fetcher.sv
module trb_ring_fetcher
  import trb_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LEN_W   = 17,
  parameter int unsigned BURST_W = 8,
  parameter int unsigned STS_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  ring_base,
  input  logic               doorbell,
  input  logic               ep_reset,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [DATA_W-1:0]  mem_rd_data,
  output logic               xfer_valid,
  input  logic               xfer_ready,
  output logic [ADDR_W-1:0]  xfer_addr,
  output logic [LEN_W-1:0]   xfer_len,
  output logic [BURST_W-1:0] xfer_burst,
  input  logic               done_valid,
  input  logic [LEN_W-1:0]   done_len,
  input  logic               sts_clr_valid,
  input  logic [STS_W-1:0]   sts_clr_mask,
  input  logic [STS_W-1:0]   sts_irq_en,
  output logic [STS_W-1:0]   sts_q,
  output logic               irq,
  output logic               ccs,
  output logic               busy
);
  localparam int unsigned WORDS = 3;
  localparam logic [ADDR_W-1:0] ADV = ADDR_W'(DESC_BYTES);
  localparam logic [STS_W-1:0] ONE = STS_W'(1);

  fetch_state_t state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, fetch_addr;
  logic              ccs_q, ccs_d, skip_q, skip_d;
  logic              go_fetch, ld_done;
  logic [WORDS-1:0][DATA_W-1:0] dw;
  logic [31:0] bw, lw, cw;

  // named internal events, observed by the checker
  logic ev_miss, ev_bad, ev_link_tgl, ev_done, ev_short_flag, ev_over;
  logic halted;
  logic [STS_W-1:0] set_mask;

  assign bw = 32'(dw[0]);
  assign lw = 32'(dw[1]);
  assign cw = 32'(dw[2]);

  trb_word_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_loader (
    .clk(clk), .rst_n(rst_n), .kill(ep_reset), .start(go_fetch), .base(fetch_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .words(dw), .done(ld_done)
  );

  always_comb begin
    state_d = state_q; ptr_d = ptr_q; ccs_d = ccs_q; skip_d = skip_q;
    go_fetch = 1'b0; fetch_addr = ptr_q;
    ev_miss = 1'b0; ev_bad = 1'b0; ev_link_tgl = 1'b0;
    ev_done = 1'b0; ev_short_flag = 1'b0; ev_over = 1'b0;
    unique case (state_q)
      S_IDLE: if (doorbell) begin
        go_fetch = 1'b1;
        state_d  = S_FETCH;
      end
      S_FETCH: if (ld_done) state_d = S_DECODE;
      S_DECODE: begin
        if (cw[C_CYCLE] != ccs_q) begin
          ev_miss = 1'b1;
          state_d = S_IDLE;
        end else if (desc_kind(cw) == KIND_LINK) begin
          ptr_d       = ADDR_W'(link_target(bw));
          fetch_addr  = ptr_d;
          ev_link_tgl = cw[C_TOGGLE];
          if (cw[C_TOGGLE]) ccs_d = ~ccs_q;
          go_fetch    = 1'b1;
          state_d     = S_FETCH;
        end else if (desc_kind(cw) == KIND_NORMAL) begin
          if (skip_q) begin
            ptr_d      = ptr_q + ADV;
            fetch_addr = ptr_d;
            go_fetch   = 1'b1;
            state_d    = S_FETCH;
            if (!cw[C_CHAIN]) begin
              skip_d  = 1'b0;
              ev_done = cw[C_DONEIRQ];
            end
          end else begin
            state_d = S_ISSUE;
          end
        end else begin
          ev_bad  = 1'b1;
          state_d = S_HALT;
        end
      end
      S_ISSUE: if (xfer_ready) state_d = S_WAIT;
      S_WAIT: if (done_valid) begin
        ev_over       = done_len > desc_len(lw);
        ev_short_flag = (done_len < desc_len(lw)) && cw[C_SPKT];
        skip_d        = (done_len < desc_len(lw)) && cw[C_CHAIN];
        ev_done       = cw[C_DONEIRQ] && !skip_d;
        ptr_d         = ptr_q + ADV;
        fetch_addr    = ptr_d;
        go_fetch      = 1'b1;
        state_d       = S_FETCH;
      end
      S_HALT: state_d = S_HALT;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; ptr_q <= '0; ccs_q <= 1'b1; skip_q <= 1'b0;
    end else if (ep_reset) begin
      state_q <= S_IDLE; ptr_q <= ring_base; ccs_q <= 1'b1; skip_q <= 1'b0;
    end else begin
      state_q <= state_d; ptr_q <= ptr_d; ccs_q <= ccs_d; skip_q <= skip_d;
    end
  end

  assign halted     = (state_q == S_HALT);
  assign busy       = (state_q != S_IDLE) && !halted;
  assign ccs        = ccs_q;
  assign xfer_valid = (state_q == S_ISSUE);
  assign xfer_addr  = ADDR_W'(bw);
  assign xfer_len   = LEN_W'(desc_len(lw));
  assign xfer_burst = BURST_W'(desc_burst(lw));
  assign set_mask   = ({STS_W{ev_done}}       & (ONE << ST_DONE))
                    | ({STS_W{ev_short_flag}} & (ONE << ST_SHORT))
                    | ({STS_W{ev_miss}}       & (ONE << ST_MISS))
                    | ({STS_W{ev_bad}}        & (ONE << ST_BAD))
                    | ({STS_W{ev_over}}       & (ONE << ST_OVER));

  trb_status_bank #(.STS_W(STS_W)) u_status (
    .clk(clk), .rst_n(rst_n), .kill(ep_reset), .set_mask(set_mask),
    .clr_mask(sts_clr_valid ? sts_clr_mask : '0), .irq_en(sts_irq_en),
    .busy(busy), .cyc(ccs_q), .sts(sts_q), .irq(irq)
  );
endmodule

// File: rtl/trb_ring_fetcher_chk.sv
module trb_ring_fetcher_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LEN_W   = 17,
  parameter int unsigned BURST_W = 8,
  parameter int unsigned STS_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ep_reset,
  input logic               xfer_valid,
  input logic               xfer_ready,
  input logic [ADDR_W-1:0]  xfer_addr,
  input logic [LEN_W-1:0]   xfer_len,
  input logic [BURST_W-1:0] xfer_burst,
  input logic [STS_W-1:0]   sts_q,
  input logic               ccs,
  input logic               busy,
  input logic               ev_miss,
  input logic               ev_bad,
  input logic               ev_link_tgl,
  input logic               halted
);
  a_r2_miss_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss && !ep_reset) |=> !busy);

  a_r3_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready && !ep_reset) |=>
      (xfer_valid && $stable(xfer_addr) && $stable(xfer_len) && $stable(xfer_burst)));

  a_r4_toggle_flips_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_link_tgl && !ep_reset) |=> (ccs != $past(ccs)));

  a_r8_bad_desc_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bad && !ep_reset) |=> (halted && sts_q[7]));

  a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !ep_reset) |=> (halted && !busy && !xfer_valid));

  a_r11_ep_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    ep_reset |=> (!busy && ccs && sts_q == STS_W'(16'h0800)));
endmodule

bind trb_ring_fetcher trb_ring_fetcher_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_W(BURST_W), .STS_W(STS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ep_reset(ep_reset), .xfer_valid(xfer_valid),
  .xfer_ready(xfer_ready), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
  .xfer_burst(xfer_burst), .sts_q(sts_q), .ccs(ccs), .busy(busy),
  .ev_miss(ev_miss), .ev_bad(ev_bad), .ev_link_tgl(ev_link_tgl), .halted(halted)
);

// File: tb/trb_ring_fetcher_bench.sv
`timescale 1ns/1ps
module trb_ring_fetcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = 32'h40;
  logic        doorbell = 1'b0, ep_reset = 1'b0;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        xfer_valid, xfer_ready = 1'b0;
  logic [31:0] xfer_addr;
  logic [16:0] xfer_len;
  logic [7:0]  xfer_burst;
  logic        done_valid = 1'b0;
  logic [16:0] done_len = '0;
  logic        sts_clr_valid = 1'b0;
  logic [15:0] sts_clr_mask = '0, sts_irq_en = '0;
  logic [15:0] sts_q;
  logic        irq, ccs, busy;

  int checks = 0, errors = 0;
  int rd_count = 0;
  logic [31:0] rd_hist [0:2];
  bit  xfer_expected = 1'b0;
  bit  finished = 1'b0;
  logic [31:0] mem [0:63];

  always #2 clk = ~clk;

  trb_ring_fetcher u_trb_ring_fetcher (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .doorbell(doorbell),
    .ep_reset(ep_reset), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_burst(xfer_burst), .done_valid(done_valid), .done_len(done_len),
    .sts_clr_valid(sts_clr_valid), .sts_clr_mask(sts_clr_mask), .sts_irq_en(sts_irq_en),
    .sts_q(sts_q), .irq(irq), .ccs(ccs), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input int kind, input bit cyc, input bit tgl,
                                      input bit spkt, input bit chain, input bit doneirq);
    return (32'(kind) << 10) | (32'(doneirq) << 5) | (32'(chain) << 4) |
           (32'(spkt) << 2) | (32'(tgl) << 1) | 32'(cyc);
  endfunction

  task automatic put(input int slot, input logic [31:0] b, input logic [31:0] l, input logic [31:0] c);
    mem[16 + 3*slot]     = b;
    mem[16 + 3*slot + 1] = l;
    mem[16 + 3*slot + 2] = c;
  endtask

  // memory model: answers each read request one cycle later
  initial forever begin
    @(negedge clk);
    if (mem_rd_en) begin
      mem_rd_valid = 1'b1;
      mem_rd_data  = mem[mem_rd_addr[7:2]];
      rd_hist[0] = rd_hist[1]; rd_hist[1] = rd_hist[2]; rd_hist[2] = mem_rd_addr;
      rd_count++;
    end else begin
      mem_rd_valid = 1'b0;
    end
  end

  // per-clock comparison against the bench's expectations
  initial forever begin
    @(negedge clk);
    if (rst_n && !finished) begin
      check(xfer_expected || !xfer_valid, "R6 unexpected transfer request", 32'(xfer_valid), 32'd0);
      check(sts_q[9] == busy && sts_q[11] == ccs, "R9 busy/cycle status bits",
            32'(sts_q), {20'd0, ccs, 1'b0, busy, 9'd0});
    end
  end

  task automatic ring();
    doorbell = 1'b1;
    @(negedge clk);
    doorbell = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    while (busy && t < 500) begin @(negedge clk); t++; end
    check(!busy, req, 32'(busy), 32'd0);
  endtask

  task automatic clear(input logic [15:0] m);
    sts_clr_valid = 1'b1; sts_clr_mask = m;
    @(negedge clk);
    sts_clr_valid = 1'b0; sts_clr_mask = '0;
  endtask

  task automatic serve(input logic [31:0] ea, input logic [16:0] el, input logic [7:0] eb,
                       input logic [16:0] moved, input string req);
    int t = 0;
    xfer_expected = 1'b1;
    while (!xfer_valid && t < 500) begin @(negedge clk); t++; end
    check(xfer_valid, req, 32'(xfer_valid), 32'd1);
    check(xfer_addr == ea, req, xfer_addr, ea);
    check(xfer_len == el, req, 32'(xfer_len), 32'(el));
    check(xfer_burst == eb, req, 32'(xfer_burst), 32'(eb));
    @(negedge clk);
    @(negedge clk);
    check(xfer_valid && xfer_addr == ea && xfer_len == el, "R3 request held without ready",
          xfer_addr, ea);
    xfer_ready = 1'b1;
    @(negedge clk);
    xfer_ready = 1'b0;
    xfer_expected = 1'b0;
    done_valid = 1'b1; done_len = moved;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int snap;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int i = 0; i < 3; i++) rd_hist[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 power-up state
    check(sts_q == 16'h0800 && !irq && !busy && ccs, "R11 reset status", 32'(sts_q), 32'h0800);
    check(!xfer_valid && !mem_rd_en, "R11 reset outputs", 32'(xfer_valid), 32'd0);
    ep_reset = 1'b1; @(negedge clk); ep_reset = 1'b0; @(negedge clk);

    // R2 / R1: empty ring reports missing descriptor
    put(0, 32'h0, 32'h0, ctl(1, 0, 0, 0, 0, 0));
    ring();
    wait_idle("R2 idle after missing");
    check(sts_q == 16'h0810, "R2 missing status", 32'(sts_q), 32'h0810);
    check(rd_hist[0] == 32'h40 && rd_hist[1] == 32'h44 && rd_hist[2] == 32'h48,
          "R1 word addresses", rd_hist[2], 32'h48);
    check(!irq, "R10 missing not enabled", 32'(irq), 32'd0);
    sts_irq_en = 16'h0010; @(negedge clk);
    check(irq, "R10 missing enabled", 32'(irq), 32'd1);
    clear(16'h0010);
    check(sts_q == 16'h0800 && !irq, "R9 write-one clear", 32'(sts_q), 32'h0800);

    // R3 / R5: one normal descriptor with completion flag
    put(0, 32'h2000, (32'd8 << 24) | 32'd300, ctl(1, 1, 0, 0, 0, 1));
    put(1, 32'h0, 32'h0, ctl(1, 0, 0, 0, 0, 0));
    ring();
    serve(32'h2000, 17'd300, 8'd8, 17'd300, "R3 normal descriptor decode");
    wait_idle("R5 runs on to next descriptor");
    check(sts_q == 16'h0814, "R5 completion status", 32'(sts_q), 32'h0814);
    check(rd_hist[2] == 32'h54, "R5 advance by 12", rd_hist[2], 32'h54);
    check(irq, "R10 completion always enabled", 32'(irq), 32'd1);
    clear(16'h0014);

    // R6: short packet in a chain skips the rest
    put(1, 32'h3000, 32'd100, ctl(1, 1, 0, 1, 1, 0));
    put(2, 32'h3100, 32'd50,  ctl(1, 1, 0, 0, 1, 0));
    put(3, 32'h3200, 32'd70,  ctl(1, 1, 0, 0, 0, 1));
    put(4, 32'h0, 32'h0, ctl(1, 0, 0, 0, 0, 0));
    ring();
    serve(32'h3000, 17'd100, 8'd0, 17'd40, "R6 first chained descriptor");
    wait_idle("R6 chain skipped without transfers");
    check(sts_q == 16'h081C, "R6 short and last completion", 32'(sts_q), 32'h081C);
    check(rd_hist[2] == 32'h78, "R6 skip reaches slot after chain", rd_hist[2], 32'h78);
    clear(16'h001C);

    // R7: overrun, partial clear
    put(4, 32'h4000, 32'd20, ctl(1, 1, 0, 0, 0, 0));
    put(5, 32'h0, 32'h0, ctl(1, 0, 0, 0, 0, 0));
    ring();
    serve(32'h4000, 17'd20, 8'd0, 17'd30, "R7 overrun descriptor");
    wait_idle("R7 idle");
    check(sts_q == 16'h4810, "R7 overrun status", 32'(sts_q), 32'h4810);
    sts_irq_en = 16'h0000; @(negedge clk);
    check(!irq, "R10 all gated off", 32'(irq), 32'd0);
    sts_irq_en = 16'h4000; @(negedge clk);
    check(irq, "R10 overrun enabled", 32'(irq), 32'd1);
    clear(16'h4000);
    check(sts_q == 16'h0810, "R9 unwritten bit kept", 32'(sts_q), 32'h0810);
    clear(16'h0010);

    // R4: toggling link back to the base
    put(5, 32'h43, 32'h0, ctl(6, 1, 1, 0, 0, 0));
    ring();
    wait_idle("R4 idle after link");
    check(!ccs && sts_q == 16'h0010, "R4 cycle inverted, stale slot missing", 32'(sts_q), 32'h0010);
    check(rd_hist[0] == 32'h40 && rd_hist[2] == 32'h48, "R4 jump to link target", rd_hist[0], 32'h40);
    clear(16'h0010);
    put(0, 32'h5000, 32'd10, ctl(1, 0, 0, 0, 0, 0));
    ring();
    serve(32'h5000, 17'd10, 8'd0, 17'd10, "R2 owned under inverted cycle");
    wait_idle("R2 idle second lap");
    check(sts_q == 16'h0010 && rd_hist[2] == 32'h54, "R2 old-lap slot missing", rd_hist[2], 32'h54);
    clear(16'h0010);

    // R8: unknown type halts
    put(1, 32'h0, 32'h0, ctl(3, 0, 0, 0, 0, 0));
    ring();
    repeat (10) @(negedge clk);
    check(sts_q == 16'h0080 && !busy, "R8 descriptor error", 32'(sts_q), 32'h0080);
    snap = rd_count;
    ring();
    repeat (10) @(negedge clk);
    check(rd_count == snap && !busy, "R8 doorbell ignored while halted", 32'(rd_count), 32'(snap));

    // R11: endpoint reset recovers
    ep_reset = 1'b1; @(negedge clk); ep_reset = 1'b0; @(negedge clk);
    check(sts_q == 16'h0800 && ccs, "R11 endpoint reset", 32'(sts_q), 32'h0800);
    ring();
    wait_idle("R11 restart");
    check(rd_hist[0] == 32'h40 && sts_q == 16'h0810, "R11 position back at base", rd_hist[0], 32'h40);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule